// File: doc/BRIEF.md
# Control Loop Sampling Scheduler

This block aligns measurement capture and control computation to the switching period of a center-aligned PWM drive. The analog converter and the rotor position reader run freely and deliver a stream of sample strobes with data. A period-start strobe marks the beginning of each switching cycle. From each stream the scheduler keeps one sample: the one with a fixed ordinal number counted from the period start. The ordinals are chosen so that the kept samples fall in the middle of the cycle (by default the 125th of about 250 converter samples and the 4th of about 7 position readings).

Both kept values go into holding registers. Once both have been latched in the current period, an interrupt is raised to start the field-oriented control computation. Software ends the computation with a single completion strobe, which stands for the acknowledgement and the new duty write. The scheduler enforces a calculation deadline, counted in clock cycles after the interrupt rises, and it also treats the next period start as a hard limit. A late completion sets a sticky overrun flag. A period that ends before the chosen ordinal arrives sets a sticky missing-sample flag for that stream, and the held value stays as it was.

Top module: `foc_sample_sched`

## Requirements
- R1: After reset the holding registers read zero, and irq_o, overrun_o, adc_miss_o and pos_miss_o are all low.
- R2: The ADC_PICK-th adc_vld_i strobe since the last period start copies adc_data_i into cur_hold_o at that clock edge. No other strobe changes cur_hold_o. A period with fewer strobes raises no interrupt.
- R3: The POS_PICK-th pos_vld_i strobe since the last period start copies pos_data_i into pos_hold_o at that clock edge. No other strobe changes pos_hold_o.
- R4: Both ordinal counts restart at every period_start_i. A strobe sampled in the same cycle as period_start_i counts as sample number 1 of the new period.
- R5: irq_o rises at the clock edge after the later of the two captures of a period, so it is one cycle behind the last holding-register update. It rises at most once per period.
- R6: irq_o falls at the edge that samples calc_done_i high. A calc_done_i while irq_o is low has no effect on irq_o or on any flag.
- R7: If calc_done_i has not been sampled within DEADLINE_CYC clock edges after irq_o rises, overrun_o is set and irq_o falls at the edge DEADLINE_CYC after the rise. Completion at exactly edge DEADLINE_CYC is still in time.
- R8: A period_start_i while irq_o is high and calc_done_i is low sets overrun_o and drops irq_o.
- R9: At each period_start_i except the first after reset, adc_miss_o (or pos_miss_o) is set if the period just ended did not capture the ADC (or position) sample. The holding register then keeps its earlier value.
- R10: err_clr_i clears all three flags. If a flag's set condition occurs in the same cycle as err_clr_i, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_start_i | input | 1 | One-cycle strobe at the start of each switching period |
| adc_vld_i | input | 1 | Converter sample strobe |
| adc_data_i | input | ADC_W | Converter sample value |
| pos_vld_i | input | 1 | Position reading strobe |
| pos_data_i | input | POS_W | Position reading value |
| calc_done_i | input | 1 | Software completion strobe (acknowledgement and duty write) |
| err_clr_i | input | 1 | Clears the sticky flags |
| cur_hold_o | output | ADC_W | Latched phase-current sample |
| pos_hold_o | output | POS_W | Latched rotor-position sample |
| irq_o | output | 1 | Control computation request, high until completion or overrun |
| overrun_o | output | 1 | Sticky deadline-miss flag |
| adc_miss_o | output | 1 | Sticky missing converter sample flag |
| pos_miss_o | output | 1 | Sticky missing position sample flag |

## Verification
The stimulus runs full periods whose data values encode their cycle index, so a capture from the wrong ordinal shows up as a different value. One spacing puts the converter sample last and another puts the position sample last, which shows that the interrupt waits for the later of the two. Further periods have one stream too short, to test the missing-sample flags and the held values. The completion strobe is placed just inside the deadline, one cycle past it, absent until the next period start, and outside any interrupt. This separates timer overruns from period-boundary overruns and from ignored strobes.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef logic [15:0] ord_t;

  typedef enum logic {GD_IDLE, GD_BUSY} guard_st_e;

  // count seen so far in this period, restarting on a period strobe
  function automatic ord_t ord_base(ord_t cnt, logic start);
    return start ? '0 : cnt;
  endfunction

  // the strobe in this cycle is the chosen ordinal
  function automatic logic ord_hit(ord_t base, logic vld, ord_t pick);
    return vld && (base == pick - 16'd1);
  endfunction

  // advance, saturating at the chosen ordinal
  function automatic ord_t ord_next(ord_t base, logic vld, ord_t pick);
    return (vld && (base < pick)) ? base + 16'd1 : base;
  endfunction

endpackage

// File: rtl/ordinal_picker.sv
module ordinal_picker
  import sched_pkg::*;
#(
  parameter int DW   = 16,
  parameter int PICK = 125
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          vld_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] hold_o,
  output logic          got_o,
  output logic          miss_o
);

  localparam ord_t PICK_O = ord_t'(PICK);

  ord_t cnt_q;
  ord_t base_w;
  logic hit_w;
  logic seen_q;

  assign base_w = ord_base(cnt_q, start_i);
  assign hit_w  = ord_hit(base_w, vld_i, PICK_O);
  // period closes without the chosen sample (not for the first start)
  assign miss_o = start_i && seen_q && !got_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      got_o  <= 1'b0;
      seen_q <= 1'b0;
      hold_o <= '0;
    end else begin
      cnt_q <= ord_next(base_w, vld_i, PICK_O);
      got_o <= start_i ? hit_w : (got_o | hit_w);
      if (start_i) seen_q <= 1'b1;
      if (hit_w) hold_o <= data_i;
    end
  end

  // R2 / R3: held value moves only on an accepted strobe
  p_hold_stable_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(hold_o));

  // R4: ordinal count never runs past the chosen sample
  p_cnt_bound_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= PICK_O);

  // R4: a period strobe without a sample empties the count
  p_cnt_restart_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !vld_i) |=> (cnt_q == '0));

endmodule

// File: rtl/deadline_guard.sv
module deadline_guard
  import sched_pkg::*;
#(
  parameter int DEADLINE = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic start_i,
  input  logic done_i,
  output logic irq_o,
  output logic ovr_o
);

  localparam int TW = $clog2(DEADLINE + 1);
  localparam logic [TW-1:0] LAST = TW'(DEADLINE - 1);

  guard_st_e st_q;
  logic [TW-1:0] tmr_q;
  logic late_w;

  assign irq_o  = (st_q == GD_BUSY);
  assign late_w = start_i || (tmr_q == LAST);
  assign ovr_o  = irq_o && !done_i && late_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= GD_IDLE;
      tmr_q <= '0;
    end else begin
      case (st_q)
        GD_IDLE: begin
          tmr_q <= '0;
          if (fire_i) st_q <= GD_BUSY;
        end
        GD_BUSY: begin
          if (done_i || late_w) begin
            st_q  <= GD_IDLE;
            tmr_q <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: st_q <= GD_IDLE;
      endcase
    end
  end

  // R6: completion ends the request at the next edge
  p_irq_drop_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && done_i) |=> !irq_o);

  // R7: timer never passes the deadline
  p_tmr_bound_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q <= LAST);

endmodule

// File: rtl/foc_sample_sched.sv
module foc_sample_sched
  import sched_pkg::*;
#(
  parameter int ADC_W       = 16,
  parameter int POS_W       = 16,
  parameter int ADC_PICK    = 125,
  parameter int POS_PICK    = 4,
  parameter int DEADLINE_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_start_i,
  input  logic             adc_vld_i,
  input  logic [ADC_W-1:0] adc_data_i,
  input  logic             pos_vld_i,
  input  logic [POS_W-1:0] pos_data_i,
  input  logic             calc_done_i,
  input  logic             err_clr_i,
  output logic [ADC_W-1:0] cur_hold_o,
  output logic [POS_W-1:0] pos_hold_o,
  output logic             irq_o,
  output logic             overrun_o,
  output logic             adc_miss_o,
  output logic             pos_miss_o
);

  localparam int NFLAG = 3;

  logic adc_got, pos_got;
  logic adc_miss_evt, pos_miss_evt, ovr_evt;
  logic fired_q, fire_w;
  logic [NFLAG-1:0] flag_evt, flag_q;

  ordinal_picker #(.DW(ADC_W), .PICK(ADC_PICK)) u_adc_pick (
    .clk(clk), .rst_n(rst_n), .start_i(period_start_i),
    .vld_i(adc_vld_i), .data_i(adc_data_i),
    .hold_o(cur_hold_o), .got_o(adc_got), .miss_o(adc_miss_evt)
  );

  ordinal_picker #(.DW(POS_W), .PICK(POS_PICK)) u_pos_pick (
    .clk(clk), .rst_n(rst_n), .start_i(period_start_i),
    .vld_i(pos_vld_i), .data_i(pos_data_i),
    .hold_o(pos_hold_o), .got_o(pos_got), .miss_o(pos_miss_evt)
  );

  // one request per period, once both samples are latched
  assign fire_w = adc_got && pos_got && !fired_q && !period_start_i;

  always_ff @(posedge clk) begin
    if (!rst_n) fired_q <= 1'b0;
    else        fired_q <= period_start_i ? 1'b0 : (fired_q | fire_w);
  end

  deadline_guard #(.DEADLINE(DEADLINE_CYC)) u_guard (
    .clk(clk), .rst_n(rst_n), .fire_i(fire_w), .start_i(period_start_i),
    .done_i(calc_done_i), .irq_o(irq_o), .ovr_o(ovr_evt)
  );

  assign flag_evt = {ovr_evt, pos_miss_evt, adc_miss_evt};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= flag_evt[g] | (flag_q[g] & ~err_clr_i);
    end
  end

  assign adc_miss_o = flag_q[0];
  assign pos_miss_o = flag_q[1];
  assign overrun_o  = flag_q[2];

  // R5: request follows both captures
  p_irq_after_both_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(adc_got && pos_got));

  // R7: overrun only while a request was pending
  p_ovr_needs_irq_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> $past(irq_o));

  // R8: period boundary during a pending request is an overrun
  p_ovr_on_start_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && period_start_i && !calc_done_i) |=> (overrun_o && !irq_o));

  // R9: missing-sample flags appear only at a period boundary
  p_adc_miss_at_start_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_miss_o) |-> $past(period_start_i));

  p_pos_miss_at_start_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pos_miss_o) |-> $past(period_start_i));

endmodule

// File: tb/foc_sample_sched_tb.sv
module foc_sample_sched_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int A_PICK = 125;
  localparam int P_PICK = 4;
  localparam int DL     = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic period_start = 1'b0, adc_vld = 1'b0, pos_vld = 1'b0;
  logic calc_done = 1'b0, err_clr = 1'b0;
  logic [15:0] adc_data = '0, pos_data = '0;
  logic [15:0] cur_hold, pos_hold;
  logic irq, overrun, adc_miss, pos_miss;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  logic irq_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  foc_sample_sched #(
    .ADC_W(16), .POS_W(16), .ADC_PICK(A_PICK), .POS_PICK(P_PICK), .DEADLINE_CYC(DL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .period_start_i(period_start),
    .adc_vld_i(adc_vld), .adc_data_i(adc_data),
    .pos_vld_i(pos_vld), .pos_data_i(pos_data),
    .calc_done_i(calc_done), .err_clr_i(err_clr),
    .cur_hold_o(cur_hold), .pos_hold_o(pos_hold),
    .irq_o(irq), .overrun_o(overrun), .adc_miss_o(adc_miss), .pos_miss_o(pos_miss)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_inputs();
    period_start = 1'b0; adc_vld = 1'b0; pos_vld = 1'b0;
    calc_done = 1'b0; err_clr = 1'b0;
  endtask

  // driver: one switching period; pushes the expected captured pair
  task automatic run_period(input int len, input int n_adc, input int n_pos,
                            input int step, input int dly,
                            input logic [15:0] aseed, input logic [15:0] pseed,
                            input logic clr0,
                            output logic [2:0] fl0, output int rise_at);
    bit seen = 0;
    int w = 0;
    rise_at = -1;
    fl0 = '0;
    if (n_adc >= A_PICK && n_pos >= P_PICK)
      exp_q.push_back({aseed + 16'(A_PICK - 1), pseed + 16'((P_PICK - 1) * step)});
    for (int c = 0; c < len; c++) begin
      period_start = (c == 0);
      err_clr      = (c == 0) && clr0;
      adc_vld      = (c < n_adc);
      adc_data     = aseed + 16'(c);
      pos_vld      = ((c % step) == 0) && ((c / step) < n_pos);
      pos_data     = pseed + 16'(c);
      if (seen) begin
        w++;
        calc_done = (dly != 0) && (w == dly);
      end else begin
        calc_done = 1'b0;
      end
      tick();
      if (c == 0) fl0 = {overrun, pos_miss, adc_miss};
      if (!seen && irq) begin
        seen = 1;
        rise_at = c;
        w = 0;
      end
    end
    idle_inputs();
  endtask

  // monitor: every request rise must present the next expected pair
  always @(negedge clk) begin
    if (rst_n && irq && !irq_prev) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected request", 32'h1, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk("R2 R4 current sample at request", {16'h0, cur_hold}, {16'h0, e[31:16]});
        chk("R3 R4 position sample at request", {16'h0, pos_hold}, {16'h0, e[15:0]});
      end
    end
    irq_prev = irq;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] fl;
    int ra;
    idle_inputs();
    repeat (4) tick();
    chk("R1 cur hold", {16'h0, cur_hold}, 32'h0);
    chk("R1 pos hold", {16'h0, pos_hold}, 32'h0);
    chk("R1 irq and flags", {28'h0, irq, overrun, pos_miss, adc_miss}, 32'h0);
    rst_n = 1'b1;
    tick();

    // ADC sample is the later one
    run_period(300, 250, 7, 40, 5, 16'h1000, 16'h2000, 1'b0, fl, ra);
    chk("R9 no miss at first start", {29'h0, fl}, 32'h0);
    chk("R5 request edge, adc last", ra, A_PICK);
    chk("R6 request cleared by done", {31'h0, irq}, 32'h0);

    // position sample is the later one; completion exactly at the deadline
    run_period(300, 250, 7, 45, DL, 16'h3000, 16'h4000, 1'b0, fl, ra);
    chk("R5 request edge, pos last", ra, 3 * 45 + 1);
    chk("R7 done at deadline is in time", {31'h0, overrun}, 32'h0);

    // too few converter samples
    run_period(300, 100, 7, 40, 5, 16'h5000, 16'h6000, 1'b0, fl, ra);
    chk("R2 no request when short", ra, -1);
    chk("R9 cur hold kept", {16'h0, cur_hold}, {16'h0, 16'h3000 + 16'(A_PICK - 1)});

    // completion one cycle late
    run_period(300, 250, 7, 40, DL + 1, 16'h7000, 16'h0100, 1'b0, fl, ra);
    chk("R9 adc miss flagged", {29'h0, fl}, 32'h1);
    chk("R7 overrun after deadline", {31'h0, overrun}, 32'h1);
    chk("R7 request dropped at deadline", {31'h0, irq}, 32'h0);

    err_clr = 1'b1; tick(); err_clr = 1'b0;
    chk("R10 flags cleared", {29'h0, overrun, pos_miss, adc_miss}, 32'h0);

    calc_done = 1'b1; tick(); calc_done = 1'b0; tick();
    chk("R6 stray done ignored", {28'h0, irq, overrun, pos_miss, adc_miss}, 32'h0);

    // short period, no completion: next start must overrun
    run_period(150, 150, 4, 40, 0, 16'h0200, 16'h0300, 1'b0, fl, ra);
    chk("R8 request still pending at period end", {31'h0, irq}, 32'h1);
    run_period(300, 250, 7, 40, 5, 16'h0400, 16'h0500, 1'b1, fl, ra);
    chk("R8 R10 overrun at start wins over clear", {29'h0, fl}, 32'h4);

    err_clr = 1'b1; tick(); err_clr = 1'b0;
    run_period(300, 250, 3, 40, 5, 16'h0600, 16'h0700, 1'b0, fl, ra);
    chk("R3 no request without position", ra, -1);
    run_period(300, 250, 7, 40, 5, 16'h0800, 16'h0900, 1'b0, fl, ra);
    chk("R9 pos miss flagged", {29'h0, fl}, 32'h2);
    chk("R3 pos hold updated after miss", {16'h0, pos_hold}, {16'h0, 16'h0900 + 16'(3 * 40)});

    repeat (3) tick();
    chk("R5 all expected requests seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule